// File: doc/BRIEF.md
# Audio Sample Queue Pair with DMA Request Generation

This block sits between the register side of an audio serial port and its serial engine. It keeps two 32-entry sample queues: a transmit queue that software or a DMA engine fills through a single data write port and that the serial engine drains, and a receive queue that the serial engine fills and that is emptied through the same data port's read side. Each queue compares its occupancy against a 4-bit programmable threshold. When the matching per-direction DMA enable is set, that comparison drives a request line, which lets a DMA engine move bursts of up to 16 samples.

The block also keeps two sticky error flags. One records that the serial engine asked for a transmit sample while the queue was empty. The other records that the serial engine delivered a receive sample into a full queue. Each flag has its own interrupt enable, and both feed one interrupt line. On a transmit underrun, the sample given to the serial engine is either zero or a repeat of the last sample it consumed, chosen by a control bit. A one-cycle flush empties both queues without touching the configuration.

Top module: `audio_fifo_dma`

## Requirements
- R1: After reset both levels read 0, both requests and both error flags are low, `irq` is low and `ser_tx_data` is 0. The thresholds reset to 8 (transmit) and 7 (receive), and all `cfg_ctl` bits reset to 0.
- R2: Samples leave each queue in the order they entered. `ser_tx_data` shows the oldest transmit sample, and `dat_rdata` shows the oldest receive sample.
- R3: While transmit DMA is enabled (`cfg_ctl` bit 0), `tx_dreq` is high exactly when `tx_level` is at or below the transmit threshold.
- R4: While receive DMA is enabled (`cfg_ctl` bit 1), `rx_dreq` is high exactly when `rx_level` is strictly above the receive threshold.
- R5: With a direction's DMA enable bit clear, that direction's request stays low whatever the level.
- R6: A `flush` pulse sets both levels to 0 on the next cycle. It leaves the thresholds, the control bits and the error flags unchanged.
- R7: A `ser_tx_pop` while the transmit queue is empty sets `tx_urun`. The flag stays set until a `clr_urun` pulse, and a set in the same cycle as a clear wins. With hold-last off (`cfg_ctl` bit 2 = 0), `ser_tx_data` is 0 while the queue is empty.
- R8: With hold-last on, `ser_tx_data` repeats the last sample consumed by `ser_tx_pop` while the queue is empty, including across repeated underruns.
- R9: A `ser_rx_push` into a full receive queue (32 entries, not read in that cycle) sets `rx_orun` until `clr_orun`. The incoming sample is discarded: the level stays 32 and the stored samples are unchanged.
- R10: `irq` is high exactly when (`tx_urun` and `cfg_ctl` bit 3) or (`rx_orun` and `cfg_ctl` bit 4).
- R11: Each queue holds 32 samples. A `dat_wr` to a full transmit queue is discarded, and `tx_level` stays at 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_thr_wr | input | 1 | Load both thresholds |
| cfg_tx_thr | input | 4 | Transmit threshold value |
| cfg_rx_thr | input | 4 | Receive threshold value |
| cfg_ctl_wr | input | 1 | Load control bits |
| cfg_ctl | input | 5 | bit0 tx DMA en, bit1 rx DMA en, bit2 hold-last, bit3 underrun irq en, bit4 overrun irq en |
| flush | input | 1 | Empty both queues |
| clr_urun | input | 1 | Clear transmit underrun flag |
| clr_orun | input | 1 | Clear receive overrun flag |
| dat_wr | input | 1 | Push `dat_wdata` into transmit queue |
| dat_wdata | input | 16 | Transmit sample from register side |
| dat_rd | input | 1 | Pop receive queue |
| dat_rdata | output | 16 | Oldest receive sample |
| ser_tx_pop | input | 1 | Serial engine consumes a transmit sample |
| ser_tx_data | output | 16 | Sample offered to the serial engine |
| ser_rx_push | input | 1 | Serial engine delivers a receive sample |
| ser_rx_data | input | 16 | Received sample |
| tx_level | output | 6 | Transmit queue occupancy |
| rx_level | output | 6 | Receive queue occupancy |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_urun | output | 1 | Sticky transmit underrun flag |
| rx_orun | output | 1 | Sticky receive overrun flag |
| irq | output | 1 | Interrupt |

## Verification
All state sits in one register stage, and every output is a combinational function of that state. So any stimulus applied before a rising edge shows up on levels, flags, requests, `irq` and the data outputs right after that edge, and data outputs also follow the head entry with no extra latency. The bench drives each input just after a falling edge, removes it at the next falling edge, and checks the outputs at that same falling edge, one full edge after the stimulus. Data outputs are checked before the pop that consumes them is issued.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    localparam int THR_W      = 4;
    localparam int CTL_W      = 5;
    localparam int TX_THR_RST = 8;
    localparam int RX_THR_RST = 7;

    // control bit positions, decoded by the control word writer
    localparam int CTL_TX_DMA = 0;
    localparam int CTL_RX_DMA = 1;
    localparam int CTL_HOLD   = 2;
    localparam int CTL_UIE    = 3;
    localparam int CTL_OIE    = 4;

    typedef struct packed {
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
        logic             tx_dma;
        logic             rx_dma;
        logic             hold;
        logic             uie;
        logic             oie;
    } afifo_cfg_t;

    function automatic afifo_cfg_t cfg_reset();
        afifo_cfg_t c;
        c.tx_thr = THR_W'(TX_THR_RST);
        c.rx_thr = THR_W'(RX_THR_RST);
        c.tx_dma = 1'b0;
        c.rx_dma = 1'b0;
        c.hold   = 1'b0;
        c.uie    = 1'b0;
        c.oie    = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/afifo_queue.sv
module afifo_queue #(
    parameter int SW    = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [SW-1:0] push_data,
    input  logic          pop,
    output logic [SW-1:0] head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] cnt;
    } q_st_t;

    q_st_t st_q, st_d;
    logic [SW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + AW'(1);
    endfunction

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == LW'(DEPTH));
    assign level = st_q.cnt;
    assign head  = mem[st_q.rp];

    always_comb begin
        do_pop  = pop && !empty && !flush;
        do_push = push && (!full || do_pop) && !flush;
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wp = ptr_inc(st_q.wp);
            if (do_pop)  st_d.rp = ptr_inc(st_q.rp);
            if (do_push && !do_pop)      st_d.cnt = st_q.cnt + LW'(1);
            else if (do_pop && !do_push) st_d.cnt = st_q.cnt - LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= push_data;
    end

endmodule

// File: rtl/afifo_dreq.sv
module afifo_dreq
    import afifo_pkg::*;
#(
    parameter int  LW    = 6,
    parameter bit  ABOVE = 1'b0
) (
    input  logic             en,
    input  logic [LW-1:0]    lvl,
    input  logic [THR_W-1:0] thr,
    output logic             req
);

    logic [LW-1:0] thr_x;
    assign thr_x = LW'(thr);

    generate
        if (ABOVE) begin : g_above
            always_comb req = en && (lvl > thr_x);
        end else begin : g_at_or_below
            always_comb req = en && (lvl <= thr_x);
        end
    endgenerate

endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl
    import afifo_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_wr,
    input  logic [THR_W-1:0] tx_thr_in,
    input  logic [THR_W-1:0] rx_thr_in,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_in,
    input  logic             urun_ev,
    input  logic             orun_ev,
    input  logic             clr_urun,
    input  logic             clr_orun,
    input  logic             tx_take,
    input  logic [SW-1:0]    tx_take_data,
    output afifo_cfg_t       cfg,
    output logic             urun,
    output logic             orun,
    output logic [SW-1:0]    last,
    output logic             irq
);

    typedef struct packed {
        afifo_cfg_t    cfg;
        logic          urun;
        logic          orun;
        logic [SW-1:0] last;
    } c_st_t;

    c_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (thr_wr) begin
            st_d.cfg.tx_thr = tx_thr_in;
            st_d.cfg.rx_thr = rx_thr_in;
        end
        if (ctl_wr) begin
            st_d.cfg.tx_dma = ctl_in[CTL_TX_DMA];
            st_d.cfg.rx_dma = ctl_in[CTL_RX_DMA];
            st_d.cfg.hold   = ctl_in[CTL_HOLD];
            st_d.cfg.uie    = ctl_in[CTL_UIE];
            st_d.cfg.oie    = ctl_in[CTL_OIE];
        end
        // set has priority over clear
        if (clr_urun) st_d.urun = 1'b0;
        if (urun_ev)  st_d.urun = 1'b1;
        if (clr_orun) st_d.orun = 1'b0;
        if (orun_ev)  st_d.orun = 1'b1;
        if (tx_take)  st_d.last = tx_take_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= cfg_reset();
            st_q.urun <= 1'b0;
            st_q.orun <= 1'b0;
            st_q.last <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg  = st_q.cfg;
    assign urun = st_q.urun;
    assign orun = st_q.orun;
    assign last = st_q.last;
    assign irq  = (st_q.urun && st_q.cfg.uie) || (st_q.orun && st_q.cfg.oie);

endmodule

// File: rtl/audio_fifo_dma.sv
module audio_fifo_dma
    import afifo_pkg::*;
#(
    parameter int SW    = 16,
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_thr_wr,
    input  logic [THR_W-1:0] cfg_tx_thr,
    input  logic [THR_W-1:0] cfg_rx_thr,
    input  logic             cfg_ctl_wr,
    input  logic [CTL_W-1:0] cfg_ctl,
    input  logic             flush,
    input  logic             clr_urun,
    input  logic             clr_orun,
    input  logic             dat_wr,
    input  logic [SW-1:0]    dat_wdata,
    input  logic             dat_rd,
    output logic [SW-1:0]    dat_rdata,
    input  logic             ser_tx_pop,
    output logic [SW-1:0]    ser_tx_data,
    input  logic             ser_rx_push,
    input  logic [SW-1:0]    ser_rx_data,
    output logic [LW-1:0]    tx_level,
    output logic [LW-1:0]    rx_level,
    output logic             tx_dreq,
    output logic             rx_dreq,
    output logic             tx_urun,
    output logic             rx_orun,
    output logic             irq
);

    afifo_cfg_t    cfg;
    logic [SW-1:0] tx_head, last;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          urun_ev, orun_ev, tx_take;

    afifo_queue #(.SW(SW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(dat_wr), .push_data(dat_wdata),
        .pop(ser_tx_pop), .head(tx_head), .level(tx_level),
        .full(tx_full), .empty(tx_empty)
    );

    afifo_queue #(.SW(SW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(ser_rx_push), .push_data(ser_rx_data),
        .pop(dat_rd), .head(dat_rdata), .level(rx_level),
        .full(rx_full), .empty(rx_empty)
    );

    always_comb begin
        urun_ev = ser_tx_pop && tx_empty;
        orun_ev = ser_rx_push && rx_full && !(dat_rd && !rx_empty) && !flush;
        tx_take = ser_tx_pop && !tx_empty && !flush;
        if (!tx_empty)     ser_tx_data = tx_head;
        else if (cfg.hold) ser_tx_data = last;
        else               ser_tx_data = '0;
    end

    afifo_ctrl #(.SW(SW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .thr_wr(cfg_thr_wr), .tx_thr_in(cfg_tx_thr), .rx_thr_in(cfg_rx_thr),
        .ctl_wr(cfg_ctl_wr), .ctl_in(cfg_ctl),
        .urun_ev(urun_ev), .orun_ev(orun_ev),
        .clr_urun(clr_urun), .clr_orun(clr_orun),
        .tx_take(tx_take), .tx_take_data(tx_head),
        .cfg(cfg), .urun(tx_urun), .orun(rx_orun), .last(last), .irq(irq)
    );

    afifo_dreq #(.LW(LW), .ABOVE(1'b0)) u_tx_dreq (
        .en(cfg.tx_dma), .lvl(tx_level), .thr(cfg.tx_thr), .req(tx_dreq)
    );

    afifo_dreq #(.LW(LW), .ABOVE(1'b1)) u_rx_dreq (
        .en(cfg.rx_dma), .lvl(rx_level), .thr(cfg.rx_thr), .req(rx_dreq)
    );

endmodule

// File: rtl/afifo_chk.sv
module afifo_chk #(
    parameter int DEPTH = 32,
    parameter int LW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          clr_urun,
    input logic          dat_rd,
    input logic          ser_rx_push,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          rx_dreq,
    input logic          tx_urun,
    input logic          rx_orun,
    input logic          irq
);

    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_level == '0 && rx_level == '0));

    a_r11_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

    a_r7_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_urun && !clr_urun) |=> tx_urun);

    a_r9_orun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && rx_level == LW'(DEPTH) && !dat_rd && !flush) |=> rx_orun);

    a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == LW'(DEPTH) && !dat_rd && !flush) |=> (rx_level == LW'(DEPTH)));

    a_r4_rx_dreq_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dreq |-> (rx_level != '0));

    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tx_urun || rx_orun));

endmodule

bind audio_fifo_dma afifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .clr_urun(clr_urun),
    .dat_rd(dat_rd), .ser_rx_push(ser_rx_push),
    .tx_level(tx_level), .rx_level(rx_level), .rx_dreq(rx_dreq),
    .tx_urun(tx_urun), .rx_orun(rx_orun), .irq(irq)
);

// File: tb/audio_fifo_dma_tb.sv
module audio_fifo_dma_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_thr_wr = 0, cfg_ctl_wr = 0, flush = 0;
    logic [3:0]  cfg_tx_thr = 0, cfg_rx_thr = 0;
    logic [4:0]  cfg_ctl = 0;
    logic        clr_urun = 0, clr_orun = 0;
    logic        dat_wr = 0, dat_rd = 0, ser_tx_pop = 0, ser_rx_push = 0;
    logic [15:0] dat_wdata = 0, ser_rx_data = 0;
    logic [15:0] dat_rdata, ser_tx_data;
    logic [5:0]  tx_level, rx_level;
    logic        tx_dreq, rx_dreq, tx_urun, rx_orun, irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    audio_fifo_dma u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_thr_wr(cfg_thr_wr), .cfg_tx_thr(cfg_tx_thr), .cfg_rx_thr(cfg_rx_thr),
        .cfg_ctl_wr(cfg_ctl_wr), .cfg_ctl(cfg_ctl), .flush(flush),
        .clr_urun(clr_urun), .clr_orun(clr_orun),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .dat_rdata(dat_rdata),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
        .tx_urun(tx_urun), .rx_orun(rx_orun), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle: inputs set by caller after a falling edge, released at the next
    task automatic cyc();
        @(negedge clk);
        cfg_thr_wr = 0; cfg_ctl_wr = 0; flush = 0; clr_urun = 0; clr_orun = 0;
        dat_wr = 0; dat_rd = 0; ser_tx_pop = 0; ser_rx_push = 0;
    endtask

    task automatic wr_tx(input logic [15:0] v);
        dat_wr = 1; dat_wdata = v; cyc();
    endtask
    task automatic push_rx(input logic [15:0] v);
        ser_rx_push = 1; ser_rx_data = v; cyc();
    endtask
    task automatic set_ctl(input logic [4:0] v);
        cfg_ctl_wr = 1; cfg_ctl = v; cyc();
    endtask
    task automatic do_flush();
        flush = 1; cyc();
    endtask

    task automatic t_reset();
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 tx_dreq", tx_dreq, 0);
        chk("R1 rx_dreq", rx_dreq, 0);
        chk("R1 flags", {tx_urun, rx_orun, irq}, 0);
        chk("R1 ser_tx_data", ser_tx_data, 0);
    endtask

    task automatic t_order();
        wr_tx(16'hA001); wr_tx(16'hB002); wr_tx(16'hC003);
        chk("R2 tx_level", tx_level, 3);
        chk("R2 tx head0", ser_tx_data, 16'hA001);
        ser_tx_pop = 1; cyc();
        chk("R2 tx head1", ser_tx_data, 16'hB002);
        ser_tx_pop = 1; cyc();
        chk("R2 tx head2", ser_tx_data, 16'hC003);
        ser_tx_pop = 1; cyc();
        chk("R2 tx drained", tx_level, 0);
        push_rx(16'h1111); push_rx(16'h2222); push_rx(16'h3333);
        chk("R2 rx head0", dat_rdata, 16'h1111);
        dat_rd = 1; cyc();
        chk("R2 rx head1", dat_rdata, 16'h2222);
        dat_rd = 1; cyc();
        chk("R2 rx head2", dat_rdata, 16'h3333);
        dat_rd = 1; cyc();
        chk("R2 rx drained", rx_level, 0);
        chk("R2 no flags", {tx_urun, rx_orun}, 0);
    endtask

    task automatic t_tx_dreq();
        set_ctl(5'b00001);
        chk("R3 empty requests", tx_dreq, 1);
        for (int i = 0; i < 8; i++) wr_tx(16'(i));
        chk("R3 level 8 at default thr", tx_dreq, 1);
        wr_tx(16'h0008);
        chk("R3 level 9 above thr", tx_dreq, 0);
        ser_tx_pop = 1; cyc();
        chk("R3 back to 8", tx_dreq, 1);
        set_ctl(5'b00000);
        chk("R5 tx enable clear", tx_dreq, 0);
        do_flush();
    endtask

    task automatic t_rx_dreq();
        set_ctl(5'b00010);
        for (int i = 0; i < 7; i++) push_rx(16'(i));
        chk("R4 level 7 at default thr", rx_dreq, 0);
        push_rx(16'h0007);
        chk("R4 level 8 above thr", rx_dreq, 1);
        set_ctl(5'b00000);
        chk("R5 rx enable clear", rx_dreq, 0);
    endtask

    task automatic t_flush();
        cfg_thr_wr = 1; cfg_tx_thr = 4'd3; cfg_rx_thr = 4'd2; cyc();
        set_ctl(5'b00011);
        wr_tx(16'h0001); wr_tx(16'h0002); wr_tx(16'h0003); wr_tx(16'h0004);
        chk("R6 pre tx_dreq", tx_dreq, 0);
        chk("R6 pre rx_dreq", rx_dreq, 1);
        do_flush();
        chk("R6 levels zero", {tx_level, rx_level}, 0);
        chk("R6 tx req after flush", tx_dreq, 1);
        chk("R6 rx req after flush", rx_dreq, 0);
        push_rx(16'h0001); push_rx(16'h0002);
        chk("R6 rx thr kept (2)", rx_dreq, 0);
        push_rx(16'h0003);
        chk("R6 rx thr kept (3)", rx_dreq, 1);
        do_flush();
        cfg_thr_wr = 1; cfg_tx_thr = 4'd8; cfg_rx_thr = 4'd7; cyc();
    endtask

    task automatic t_underrun();
        set_ctl(5'b01000);
        ser_tx_pop = 1; cyc();
        chk("R7 urun set", tx_urun, 1);
        chk("R10 irq on urun", irq, 1);
        chk("R7 zero out", ser_tx_data, 0);
        repeat (3) cyc();
        chk("R7 urun sticky", tx_urun, 1);
        do_flush();
        chk("R6 flush keeps flag", tx_urun, 1);
        ser_tx_pop = 1; clr_urun = 1; cyc();
        chk("R7 set beats clear", tx_urun, 1);
        clr_urun = 1; cyc();
        chk("R7 cleared", tx_urun, 0);
        chk("R10 irq cleared", irq, 0);
        wr_tx(16'h5A5A);
        chk("R7 head shown", ser_tx_data, 16'h5A5A);
        ser_tx_pop = 1; cyc();
        chk("R7 zero after drain", ser_tx_data, 0);
        chk("R7 no urun on valid pop", tx_urun, 0);
    endtask

    task automatic t_hold();
        set_ctl(5'b00100);
        wr_tx(16'h1234);
        ser_tx_pop = 1; cyc();
        chk("R8 hold repeats", ser_tx_data, 16'h1234);
        ser_tx_pop = 1; cyc();
        chk("R8 hold across underrun", ser_tx_data, 16'h1234);
        chk("R8 urun flagged", tx_urun, 1);
        chk("R10 urun masked", irq, 0);
        clr_urun = 1; cyc();
        set_ctl(5'b00000);
    endtask

    task automatic t_overrun();
        set_ctl(5'b10000);
        for (int i = 0; i < 32; i++) push_rx(16'h0100 + 16'(i));
        chk("R11 rx full level", rx_level, 32);
        chk("R9 no orun yet", rx_orun, 0);
        push_rx(16'hFFFF);
        chk("R9 orun set", rx_orun, 1);
        chk("R9 level held", rx_level, 32);
        chk("R10 irq on orun", irq, 1);
        set_ctl(5'b00000);
        chk("R10 orun masked", irq, 0);
        for (int i = 0; i < 32; i++) begin
            chk("R9 stored sample", dat_rdata, 16'h0100 + 16'(i));
            dat_rd = 1; cyc();
        end
        chk("R9 drained", rx_level, 0);
        clr_orun = 1; cyc();
        chk("R9 orun cleared", rx_orun, 0);
    endtask

    task automatic t_tx_full();
        for (int i = 0; i < 33; i++) wr_tx(16'h0200 + 16'(i));
        chk("R11 tx level capped", tx_level, 32);
        for (int i = 0; i < 32; i++) begin
            chk("R11 tx sample", ser_tx_data, 16'h0200 + 16'(i));
            ser_tx_pop = 1; cyc();
        end
        chk("R11 tx drained", tx_level, 0);
        chk("R11 extra dropped", ser_tx_data, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_order();
        t_tx_dreq();
        t_rx_dreq();
        t_flush();
        t_underrun();
        t_hold();
        t_overrun();
        t_tx_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule